// File: doc/BRIEF.md
# Gatable Square-Wave Oscillator with Divide-by-Two Output Pair

This block is a synchronous free-running square-wave source. A programmable tick count replaces an analog timing network: an internal counter wraps every `N` clock cycles, and each wrap toggles the fast oscillator tap `osc_out`. A toggle stage divides that tap by two and drives a true/complemented pair, `q_out` and `q_n_out`. Both outputs of the pair have an exact 50% duty cycle.

The block runs while either of its two gate pins is asserted. One gate is active-high and the other is active-low. Tying one gate to its active level gives free-running operation, and driving either gate from logic gives gated bursts. A high level on the clear pin stops the block and holds it in its idle state whatever the gates do.

The clear pin and both gate pins can be asynchronous. Each passes through a two-flop synchroniser. The period count is captured only while the block is idle, so a new value takes effect at the next start.

Top module: `gated_astable_osc`

## Requirements
- R1: The block runs when `run_hi` is 1 or `run_lo_n` is 0 (after synchronisation). With `run_hi`=0 and `run_lo_n`=1, `osc_out` and `q_out` stay 0 and `q_n_out` stays 1.
- R2: `q_n_out` is the bitwise complement of `q_out` on every cycle, including during reset.
- R3: While running, `osc_out` changes level every `N` clock cycles, so its period is 2N cycles. `N` is the captured `period_ticks` value.
- R4: `q_out` toggles on each falling edge of `osc_out`. It is high for 2N cycles and low for 2N cycles, so its frequency is half that of `osc_out`.
- R5: When a gate pin becomes active while the block is idle, the first rising edge of `q_out` is seen 2N+2 clock edges later. This is two synchroniser edges plus one full `osc_out` period.
- R6: While `clr` is 1, the block is forced to `q_out`=0, `q_n_out`=1 and `osc_out`=0 whatever the gate pins are. These values appear by the third clock edge after `clr` rises.
- R7: `period_ticks` is captured only while the block is idle. A change while running does not alter the output timing until the block has stopped and restarted.
- R8: A `period_ticks` value of 0 behaves as 1, which gives `osc_out` a period of 2 cycles.
- R9: `rst_n`=0 resets the block asynchronously to `q_out`=0, `q_n_out`=1 and `osc_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Active-high clear, synchronised; overrides the gates |
| run_hi | input | 1 | Active-high gate |
| run_lo_n | input | 1 | Active-low gate |
| period_ticks | input | CNT_W | Oscillator half-period in clock cycles (0 is treated as 1) |
| osc_out | output | 1 | Oscillator tap at twice the Q frequency |
| q_out | output | 1 | Divided output, 50% duty |
| q_n_out | output | 1 | Complement of q_out |

## Verification
The assertions check the following on every cycle:
- the complement relation between `q_out` and `q_n_out`;
- that an idle block drives both `osc_out` and `q_out` to zero on the next edge;
- that `osc_out` moves only after a counter wrap;
- that `q_out` moves only on a falling edge of `osc_out`.

Some behaviours depend on whole periods and pin-level latency, so only the bench's scenarios can show them. These are the exact high and low durations, the two-to-one frequency ratio, the 2N+2 start-up latency, the clamp of a zero count, the capture of the period count only while idle, and the clear override while a gate is held active.

// File: rtl/osc_pkg.sv
package osc_pkg;
  localparam int unsigned OSC_CNT_W_DEF = 8;

  typedef enum logic [1:0] {
    SYNC_CLR = 2'd0,
    SYNC_HI  = 2'd1,
    SYNC_LON = 2'd2
  } sync_idx_e;

  function automatic logic [OSC_CNT_W_DEF-1:0] clamp_min1(input logic [OSC_CNT_W_DEF-1:0] v);
    return (v == '0) ? {{(OSC_CNT_W_DEF-1){1'b0}}, 1'b1} : v;
  endfunction
endpackage

// File: rtl/sync2.sv
module sync2 #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= RST_VAL[i];
        sync_q[i] <= RST_VAL[i];
      end else begin
        meta_q[i] <= d[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/period_counter.sv
module period_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CNT_W-1:0] period_in,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             per_en;

  // Capture the period only while idle; clamp zero to one.
  assign per_en = !active;

  always_comb begin
    per_d = (period_in == '0) ? ONE : period_in;
  end

  always_comb begin
    wrap  = active && (cnt_q == per_q - ONE);
    cnt_d = cnt_q;
    if (!active)   cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= ONE;
      cnt_q <= '0;
    end else begin
      if (per_en) per_q <= per_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/toggle_stage.sv
module toggle_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic wrap,
  output logic osc,
  output logic q
);
  logic osc_d, q_d;

  always_comb begin
    osc_d = osc;
    q_d   = q;
    if (!active) begin
      osc_d = 1'b0;
      q_d   = 1'b0;
    end else if (wrap) begin
      osc_d = !osc;
      // Divide by two: advance on the oscillator falling edge.
      if (osc) q_d = !q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc <= 1'b0;
      q   <= 1'b0;
    end else begin
      osc <= osc_d;
      q   <= q_d;
    end
  end
endmodule

// File: rtl/gated_astable_osc.sv
module gated_astable_osc #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run_hi,
  input  logic             run_lo_n,
  input  logic [CNT_W-1:0] period_ticks,
  output logic             osc_out,
  output logic             q_out,
  output logic             q_n_out
);
  import osc_pkg::*;

  logic [2:0] raw_in, sync_out;
  logic       active;
  logic       wrap;
  logic       osc_r, q_r;

  assign raw_in[SYNC_CLR] = clr;
  assign raw_in[SYNC_HI]  = run_hi;
  assign raw_in[SYNC_LON] = run_lo_n;

  sync2 #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  assign active = !sync_out[SYNC_CLR] && (sync_out[SYNC_HI] || !sync_out[SYNC_LON]);

  period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .active(active), .period_in(period_ticks), .wrap(wrap)
  );

  toggle_stage u_tog (
    .clk(clk), .rst_n(rst_n), .active(active), .wrap(wrap), .osc(osc_r), .q(q_r)
  );

  assign osc_out = osc_r;
  assign q_out   = q_r;
  assign q_n_out = !q_r;
endmodule

// File: rtl/gated_astable_osc_chk.sv
module gated_astable_osc_chk (
  input logic clk,
  input logic rst_n,
  input logic active,
  input logic wrap,
  input logic osc,
  input logic q,
  input logic q_n
);
  a_r2_complement: assert property (@(posedge clk) disable iff (!rst_n) q_n == !q)
    else $error("R2 complement broken");

  a_r1_idle_clears: assert property (@(posedge clk) disable iff (!rst_n) !active |=> (!osc && !q))
    else $error("R1/R6 idle outputs not zero");

  a_r3_osc_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      ((osc != $past(osc)) && $past(active)) |-> $past(wrap))
    else $error("R3 osc moved without wrap");

  a_r4_q_on_osc_fall: assert property (@(posedge clk) disable iff (!rst_n)
      ((q != $past(q)) && $past(active)) |-> ($past(osc) && !osc))
    else $error("R4 q moved off osc fall");
endmodule

bind gated_astable_osc gated_astable_osc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .wrap(wrap),
  .osc(osc_out), .q(q_out), .q_n(q_n_out)
);

// File: tb/gated_astable_osc_test.sv
module gated_astable_osc_test;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n, clr, run_hi, run_lo_n;
  logic [CNT_W-1:0] period_ticks;
  logic osc_out, q_out, q_n_out;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  gated_astable_osc #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run_hi(run_hi), .run_lo_n(run_lo_n),
    .period_ticks(period_ticks), .osc_out(osc_out), .q_out(q_out), .q_n_out(q_n_out)
  );

  always #10 clk = !clk;

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  // Count negedges until q_out equals val.
  task automatic wait_q(input logic val, output int n);
    n = 0;
    while (q_out !== val && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic stop_all();
    run_hi = 1'b0; run_lo_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // Start from idle, measure latency, high/low time and osc:q ratio.
  task automatic run_case(input int n, input bit use_lo, input string tag);
    int lat, hi, lo, osc_rises, q_rises;
    logic po, pq;
    period_ticks = n[CNT_W-1:0];
    @(negedge clk);
    if (use_lo) run_lo_n = 1'b0; else run_hi = 1'b1;
    wait_q(1'b1, lat);
    check({tag, " R5 latency"}, lat, 2*((n == 0) ? 1 : n) + 2);
    wait_q(1'b0, hi);
    check({tag, " R4 high time"}, hi, 2*((n == 0) ? 1 : n));
    wait_q(1'b1, lo);
    check({tag, " R4 low time"}, lo, 2*((n == 0) ? 1 : n));
    check({tag, " R2 complement"}, int'(q_n_out), int'(!q_out));
    osc_rises = 0; q_rises = 0; po = osc_out; pq = q_out;
    for (int i = 0; i < 8*((n == 0) ? 1 : n); i++) begin
      @(negedge clk);
      if (osc_out && !po) osc_rises++;
      if (q_out && !pq) q_rises++;
      po = osc_out; pq = q_out;
    end
    check({tag, " R3 osc rises"}, osc_rises, 4);
    check({tag, " R4 q rises"}, q_rises, 2);
    stop_all();
    check({tag, " R1 idle q"}, int'(q_out), 0);
    check({tag, " R1 idle osc"}, int'(osc_out), 0);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; clr = 1'b0; run_hi = 1'b1; run_lo_n = 1'b0; period_ticks = 8'd3;
    repeat (3) @(negedge clk);
    check("R9 reset q", int'(q_out), 0);
    check("R9 reset q_n", int'(q_n_out), 1);
    check("R9 reset osc", int'(osc_out), 0);
    run_hi = 1'b0; run_lo_n = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic test_idle();
    repeat (20) @(negedge clk);
    check("R1 no gate q", int'(q_out), 0);
    check("R1 no gate osc", int'(osc_out), 0);
  endtask

  task automatic test_clear();
    int n, bad;
    period_ticks = 8'd2;
    run_hi = 1'b1;
    wait_q(1'b1, n);
    @(negedge clk);
    clr = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 clear q", int'(q_out), 0);
    check("R6 clear q_n", int'(q_n_out), 1);
    check("R6 clear osc", int'(osc_out), 0);
    bad = 0;
    run_lo_n = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (q_out || osc_out) bad++;
    end
    check("R6 clear holds with gates", bad, 0);
    clr = 1'b0;
    stop_all();
  endtask

  task automatic test_period_change();
    int lat, hi;
    period_ticks = 8'd3;
    @(negedge clk);
    run_hi = 1'b1;
    wait_q(1'b1, lat);
    period_ticks = 8'd7;
    wait_q(1'b0, hi);
    check("R7 running change ignored", hi, 6);
    stop_all();
    run_hi = 1'b1;
    wait_q(1'b1, lat);
    check("R7 new period after restart", lat, 16);
    stop_all();
  endtask

  initial begin
    test_reset();
    test_idle();
    run_case(3, 1'b0, "hi-gate N3");
    run_case(5, 1'b1, "lo-gate N5");
    run_case(1, 1'b0, "N1");
    run_case(0, 1'b1, "R8 N0");
    test_clear();
    test_period_change();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule